// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

This block is a synchronous cache memory with registered address, control and read data. Each word is 18 bits, split into two 9-bit halves. A half carries eight data bits and one parity bit, and each half has its own active-low write enable. A two-bit burst sequencer steps through the four words of an aligned group. Its stepping order is chosen by a parameter: interleaved (exclusive-OR) or linear (wrap-around add).

A cycle can be opened by either of two strobes. The processor strobe captures an address and ignores the write enables on that edge. Any write it starts therefore lands on a later edge, which leaves the edge in between for a tag lookup. The controller strobe captures an address and, when a write enable is low, writes on the same edge. Between strobes, the advance input steps the burst address, and each edge either writes the input word or reads the current location. The shared data bus is split into an input word, an output word and one drive flag per half. Output enable gates the drive flags without waiting for a clock.

Top module: `burst_cache_sram`

## Requirements
- R1: Word layout. Bits 8:0 are the low half: data 7..0 in bits 7:0 and parity in bit 8. Bits 17:9 are the high half: data 15..8 in bits 16:9 and parity in bit 17. `we_lo_n` writes only the low half and `we_hi_n` writes only the high half.
- R2: With `cs_n` low, `ctrl_strobe_n` low and `proc_strobe_n` high, a low write enable writes `din` on that same edge at the address presented with it. A read of that address on the following edge returns the new word.
- R3: With `cs_n` and `proc_strobe_n` both low, the address is captured and a read occurs. Both write enables are ignored, and this holds even when `ctrl_strobe_n` is also low.
- R4: On an edge that opens no new cycle while the block is selected, a low write enable writes `din` to the current burst address. This gives the two-edge write after a processor strobe. With both enables high, that edge reads the current address instead.
- R5: Read data is registered. `dout` shows the word at the address used on the most recent reading edge, from just after that edge.
- R6: On a continuation edge, `adv_n` low steps the burst offset by one, wrapping after four steps. The upper address bits stay fixed. `adv_n` has no effect on an edge that opens a cycle, and `adv_n` high repeats the same address.
- R7: Offset order. With start offset s and step count k, `ORDER`=interleaved gives s XOR k and `ORDER`=linear gives (s+k) mod 4.
- R8: `oe_n` high forces both drive flags low at once, without waiting for a clock edge. An undriven half reads as zero on `dout`.
- R9: A half written on an edge is undriven until the next edge, whatever the level of `oe_n`. The other half stays driven.
- R10: `cs_n` high with `ctrl_strobe_n` low deselects the block, and so does reset. While deselected, both halves are undriven and continuation edges neither read nor write until a new strobe.
- R11: `proc_strobe_n` low while `cs_n` is high is ignored, and the current burst continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, sampled, active low |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| we_lo_n | input | 1 | Low-half write enable, active low |
| we_hi_n | input | 1 | High-half write enable, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| addr | input | ADDR_W | Word address |
| din | input | 2*(DATA_HALF_W+1) | Write word |
| dout | output | 2*(DATA_HALF_W+1) | Registered read word, zero on an undriven half |
| drive_lo | output | 1 | Low half drives the bus |
| drive_hi | output | 1 | High half drives the bus |

## Verification
The collision of interest is an address capture and a write on the same edge. Both strobes are driven low together with both write enables low, so the processor path must win and its masking must suppress the controller's same-edge write. The read returned on that edge, and again on the next, has to equal the word stored before. A second case drives a strobe and `adv_n` together. The word returned must come from the presented address and not from the next burst slot. A half-write on the delayed edge is then judged by one half dropping its drive while the other still shows the old contents.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic {
    ORD_INTERLEAVED = 1'b0,
    ORD_LINEAR      = 1'b1
  } burst_order_e;

  typedef struct packed {
    logic start_proc;
    logic start_ctrl;
    logic deselect;
    logic cont;
    logic advance;
    logic wr_lo;
    logic wr_hi;
    logic rd;
  } cycle_ev_t;

  // Offset inside the four-word group after `step` advances from `start`.
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] step,
                                              input burst_order_e ord);
    logic [1:0] r;
    if (ord == ORD_LINEAR) r = start + step;
    else                   r = start ^ step;
    return r;
  endfunction

endpackage

// File: rtl/bcs_decode.sv
module bcs_decode
  import burst_sram_pkg::*;
(
  input  logic      cs_n,
  input  logic      proc_strobe_n,
  input  logic      ctrl_strobe_n,
  input  logic      adv_n,
  input  logic      we_lo_n,
  input  logic      we_hi_n,
  input  logic      sel_q,
  output cycle_ev_t ev
);

  logic any_start;
  logic writable;

  always_comb begin
    ev = '0;
    // processor strobe has priority and masks the write enables
    ev.start_proc = !cs_n && !proc_strobe_n;
    ev.start_ctrl = !cs_n && proc_strobe_n && !ctrl_strobe_n;
    ev.deselect   = cs_n && !ctrl_strobe_n;
    any_start     = ev.start_proc || ev.start_ctrl || ev.deselect;
    ev.cont       = sel_q && !any_start;
    ev.advance    = ev.cont && !adv_n;
    writable      = ev.start_ctrl || ev.cont;
    ev.wr_lo      = writable && !we_lo_n;
    ev.wr_hi      = writable && !we_hi_n;
    ev.rd         = ev.start_proc || (writable && we_lo_n && we_hi_n);
  end

endmodule

// File: rtl/bcs_sequencer.sv
module bcs_sequencer
  import burst_sram_pkg::*;
#(
  parameter int           ADDR_W = 6,
  parameter burst_order_e ORDER  = ORD_INTERLEAVED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        step
);

  localparam int UPPER_W = ADDR_W - 2;

  logic [UPPER_W-1:0] upper_q;
  logic [1:0]         start_q;
  logic [1:0]         step_q;
  logic [1:0]         step_nxt;

  assign step_nxt = advance ? step_q + 2'd1 : step_q;
  assign step     = step_q;

  always_comb begin
    if (load) cur_addr = addr_in;
    else      cur_addr = {upper_q, burst_offset(start_q, step_nxt, ORDER)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      step_q  <= '0;
    end else if (load) begin
      upper_q <= addr_in[ADDR_W-1:2];
      start_q <= addr_in[1:0];
      step_q  <= '0;
    end else begin
      step_q  <= step_nxt;
    end
  end

endmodule

// File: rtl/bcs_array.sv
module bcs_array #(
  parameter int ADDR_W = 6,
  parameter int HALF_W = 9
) (
  input  logic                clk,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          wr_en,
  input  logic [2*HALF_W-1:0] wdata,
  output logic [2*HALF_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en[h]) mem[addr] <= wdata[h*HALF_W +: HALF_W];
    end

    assign rdata[h*HALF_W +: HALF_W] = mem[addr];
  end

endmodule

// File: rtl/burst_cache_sram.sv
module burst_cache_sram
  import burst_sram_pkg::*;
#(
  parameter int           ADDR_W      = 6,
  parameter int           DATA_HALF_W = 8,
  parameter burst_order_e ORDER       = ORD_INTERLEAVED
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs_n,
  input  logic                         proc_strobe_n,
  input  logic                         ctrl_strobe_n,
  input  logic                         adv_n,
  input  logic                         we_lo_n,
  input  logic                         we_hi_n,
  input  logic                         oe_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [2*(DATA_HALF_W+1)-1:0] din,
  output logic [2*(DATA_HALF_W+1)-1:0] dout,
  output logic                         drive_lo,
  output logic                         drive_hi
);

  localparam int HALF_W = DATA_HALF_W + 1;
  localparam int WORD_W = 2 * HALF_W;

  cycle_ev_t          ev;
  logic               sel_q;
  logic [1:0]         wr_q;
  logic [WORD_W-1:0]  dout_q;
  logic [ADDR_W-1:0]  cur_addr;
  logic [1:0]         step;
  logic [WORD_W-1:0]  rdata;
  logic               load;

  bcs_decode u_decode (
    .cs_n          (cs_n),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .we_lo_n       (we_lo_n),
    .we_hi_n       (we_hi_n),
    .sel_q         (sel_q),
    .ev            (ev)
  );

  assign load = ev.start_proc || ev.start_ctrl;

  bcs_sequencer #(.ADDR_W(ADDR_W), .ORDER(ORDER)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .advance  (ev.advance),
    .addr_in  (addr),
    .cur_addr (cur_addr),
    .step     (step)
  );

  bcs_array #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_array (
    .clk   (clk),
    .addr  (cur_addr),
    .wr_en ({ev.wr_hi, ev.wr_lo}),
    .wdata (din),
    .rdata (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      wr_q   <= 2'b00;
      dout_q <= '0;
    end else begin
      if (ev.deselect)  sel_q <= 1'b0;
      else if (load)    sel_q <= 1'b1;
      wr_q <= {ev.wr_hi, ev.wr_lo};
      if (ev.rd) dout_q <= rdata;
    end
  end

  assign drive_lo = !oe_n && sel_q && !wr_q[0];
  assign drive_hi = !oe_n && sel_q && !wr_q[1];

  assign dout[HALF_W-1:0]      = drive_lo ? dout_q[HALF_W-1:0] : '0;
  assign dout[WORD_W-1:HALF_W] = drive_hi ? dout_q[WORD_W-1:HALF_W] : '0;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import burst_sram_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cs_n,
  input logic      proc_strobe_n,
  input logic      ctrl_strobe_n,
  input logic      oe_n,
  input logic      drive_lo,
  input logic      drive_hi,
  input cycle_ev_t ev,
  input logic [1:0] step
);

  // R3: write enables masked when the processor strobe is taken
  a_r3_we_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !proc_strobe_n) |-> (!ev.wr_lo && !ev.wr_hi));

  // R6: a new cycle restarts the step count
  a_r6_step_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.start_proc || ev.start_ctrl) |=> (step == 2'd0));

  // R6: an advance moves the step count by exactly one
  a_r6_step_adv: assert property (@(posedge clk) disable iff (!rst_n)
    ev.advance |=> (step == 2'($past(step) + 2'd1)));

  // R8: output enable high leaves both halves undriven
  a_r8_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!drive_lo && !drive_hi));

  // R9: a written half stays quiet in the following cycle
  a_r9_lo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev.wr_lo |=> !drive_lo);
  a_r9_hi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev.wr_hi |=> !drive_hi);

  // R10: deselection turns both halves off
  a_r10_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !ctrl_strobe_n) |=> (!drive_lo && !drive_hi));

endmodule

bind burst_cache_sram bcs_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cs_n          (cs_n),
  .proc_strobe_n (proc_strobe_n),
  .ctrl_strobe_n (ctrl_strobe_n),
  .oe_n          (oe_n),
  .drive_lo      (drive_lo),
  .drive_hi      (drive_hi),
  .ev            (ev),
  .step          (step)
);

// File: tb/burst_cache_sram_test.sv
module burst_cache_sram_test;
  import burst_sram_pkg::*;

  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int WW = 18;

  logic clk = 1'b0;
  logic rst_n, cs_n, proc_n, ctrl_n, adv_n, we_lo_n, we_hi_n, oe_n;
  logic [AW-1:0] addr;
  logic [WW-1:0] din;
  logic [WW-1:0] dout_i, dout_l;
  logic dlo_i, dhi_i, dlo_l, dhi_l;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [WW-1:0] mi [DEPTH];
  logic [WW-1:0] ml [DEPTH];

  always #5 clk = ~clk;

  burst_cache_sram #(.ADDR_W(AW), .DATA_HALF_W(8), .ORDER(ORD_INTERLEAVED)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .proc_strobe_n(proc_n),
    .ctrl_strobe_n(ctrl_n), .adv_n(adv_n), .we_lo_n(we_lo_n), .we_hi_n(we_hi_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout_i),
    .drive_lo(dlo_i), .drive_hi(dhi_i));

  burst_cache_sram #(.ADDR_W(AW), .DATA_HALF_W(8), .ORDER(ORD_LINEAR)) uut_lin (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .proc_strobe_n(proc_n),
    .ctrl_strobe_n(ctrl_n), .adv_n(adv_n), .we_lo_n(we_lo_n), .we_hi_n(we_hi_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout_l),
    .drive_lo(dlo_l), .drive_hi(dhi_l));

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] pat(input int a, input int salt);
    return WW'((a * 2731 + salt * 977 + 5) % 262144);
  endfunction

  function automatic int off_i(input int s, input int k);
    logic [1:0] a, b, r;
    a = 2'(s); b = 2'(k);
    r[0] = a[0] != b[0];
    r[1] = a[1] != b[1];
    return int'(r);
  endfunction

  function automatic int off_l(input int s, input int k);
    return (s + k) % 4;
  endfunction

  task automatic idle();
    cs_n = 0; proc_n = 1; ctrl_n = 1; adv_n = 1;
    we_lo_n = 1; we_hi_n = 1; oe_n = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_drv(input string req, input logic lo, input logic hi);
    chk(req, {14'd0, dhi_i, dlo_i, dhi_l, dlo_l}, {14'd0, hi, lo, hi, lo});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); addr = '0; din = '0;
    tick(); tick();
    chk_drv("R10 reset undriven", 0, 0);
    chk("R8 reset dout zero", dout_i, '0);
    rst_n = 1;

    // R2 R9: fill memory with controller-strobe single writes
    for (int a = 0; a < DEPTH; a++) begin
      idle(); ctrl_n = 0; addr = AW'(a); we_lo_n = 0; we_hi_n = 0; din = pat(a, 0);
      tick();
      mi[a] = pat(a, 0); ml[a] = pat(a, 0);
      if (a % 8 == 0) chk_drv("R9 write undriven", 0, 0);
    end

    // R2 R5: single reads of every address
    for (int a = 0; a < DEPTH; a++) begin
      idle(); ctrl_n = 0; addr = AW'(a);
      tick();
      chk("R5 single read interleaved", dout_i, mi[a]);
      chk("R5 single read linear", dout_l, ml[a]);
    end
    chk_drv("R5 read driven", 1, 1);

    // R2: read right after write at the same address
    idle(); ctrl_n = 0; addr = 6'd10; we_lo_n = 0; we_hi_n = 0; din = pat(10, 7);
    tick(); mi[10] = pat(10, 7); ml[10] = pat(10, 7);
    idle(); ctrl_n = 0; addr = 6'd10;
    tick();
    chk("R2 read after write", dout_i, mi[10]);

    // R6 R7: burst reads from every start offset in two groups
    for (int g = 0; g < 2; g++) begin
      for (int s = 0; s < 4; s++) begin
        automatic int base = (g == 0) ? 8 : 44;
        idle(); proc_n = 0; addr = AW'(base + s); adv_n = 0;
        tick();
        chk("R6 advance ignored on strobe", dout_i, mi[base + s]);
        for (int k = 1; k <= 4; k++) begin
          idle(); adv_n = 0; addr = '0;
          tick();
          chk("R7 interleaved order", dout_i, mi[base + off_i(s, k % 4)]);
          chk("R7 linear order", dout_l, ml[base + off_l(s, k % 4)]);
        end
        idle();
        tick();
        chk("R6 hold without advance", dout_l, ml[base + s]);
      end
    end

    // R3 R4 R1 R9: processor-started write, low half then high half
    for (int h = 0; h < 2; h++) begin
      automatic int a = 20 + h;
      automatic logic [WW-1:0] nw = pat(a, 3);
      idle(); proc_n = 0; addr = AW'(a); we_lo_n = 0; we_hi_n = 0; din = ~mi[a];
      tick();
      chk("R3 strobe edge reads", dout_i, mi[a]);
      chk_drv("R3 strobe edge driven", 1, 1);
      idle(); din = nw;
      if (h == 0) we_lo_n = 0; else we_hi_n = 0;
      tick();
      if (h == 0) begin
        chk_drv("R9 low half quiet", 0, 1);
        chk("R1 high half kept", dout_i, {mi[a][17:9], 9'd0});
        mi[a][8:0] = nw[8:0]; ml[a][8:0] = nw[8:0];
      end else begin
        chk_drv("R9 high half quiet", 1, 0);
        chk("R1 low half kept", dout_i, {9'd0, mi[a][8:0]});
        mi[a][17:9] = nw[17:9]; ml[a][17:9] = nw[17:9];
      end
      idle();
      tick();
      chk("R4 delayed write landed", dout_i, mi[a]);
      chk("R1 half merge linear", dout_l, ml[a]);
    end

    // R3: both strobes low with write enables low -> read only
    idle(); proc_n = 0; ctrl_n = 0; addr = 6'd30; we_lo_n = 0; we_hi_n = 0; din = ~mi[30];
    tick();
    chk("R3 priority read", dout_i, mi[30]);
    idle();
    tick();
    chk("R3 no write on collision", dout_i, mi[30]);

    // R2 R4 R7: controller-started burst write from offset 1
    for (int k = 0; k < 4; k++) begin
      idle(); we_lo_n = 0; we_hi_n = 0; din = pat(48 + k, 9);
      if (k == 0) begin ctrl_n = 0; addr = 6'd49; end else adv_n = 0;
      tick();
      mi[48 + off_i(1, k)] = pat(48 + k, 9);
      ml[48 + off_l(1, k)] = pat(48 + k, 9);
    end
    for (int a = 48; a < 52; a++) begin
      idle(); ctrl_n = 0; addr = AW'(a);
      tick();
      chk("R4 burst write interleaved", dout_i, mi[a]);
      chk("R4 burst write linear", dout_l, ml[a]);
    end

    // R8: output enable acts without a clock
    oe_n = 1; #1;
    chk_drv("R8 oe high undriven", 0, 0);
    chk("R8 dout zero", dout_i, '0);
    oe_n = 0; #1;
    chk_drv("R8 oe low driven", 1, 1);
    chk("R8 data back", dout_i, mi[51]);

    // R10: deselect, then a continuation edge must not write
    idle(); ctrl_n = 0; addr = 6'd40;
    tick();
    idle(); cs_n = 1; ctrl_n = 0;
    tick();
    chk_drv("R10 deselect undriven", 0, 0);
    idle(); adv_n = 0; we_lo_n = 0; we_hi_n = 0; din = 18'h3FFFF;
    tick();
    chk_drv("R10 stays undriven", 0, 0);
    for (int a = 40; a < 42; a++) begin
      idle(); ctrl_n = 0; addr = AW'(a);
      tick();
      chk("R10 no write while deselected", dout_i, mi[a]);
    end

    // R11: processor strobe with chip select high is ignored
    idle(); proc_n = 0; addr = 6'd12;
    tick();
    idle(); cs_n = 1; proc_n = 0; adv_n = 0; addr = 6'd50;
    tick();
    chk("R11 burst continues interleaved", dout_i, mi[12 + off_i(0, 1)]);
    chk("R11 burst continues linear", dout_l, ml[12 + off_l(0, 1)]);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule